// File: doc/BRIEF.md
# SD Card Command Path Controller

This block drives one command exchange on the command line of an SD or MMC card. It can also take in the card's reply. Every register runs on the card clock.

Software writes a control word and a 32-bit argument in one strobe. If the enable bit is set, the block builds a 48-bit command frame with its CRC7 and shifts it out, most significant bit first. It then does one of two things:
- it reports that the command was sent, or
- it waits for the card to start a reply, takes in a 48-bit or a 136-bit frame, checks its CRC and presents the result on a 6-bit index output and four 32-bit word outputs.

Two modes change how the exchange starts or ends:
- **Deferred start:** the command is held back until an external strobe arrives.
- **Interrupt wait:** the reply timer is switched off and the wait instead ends on an interrupt request.

After each accepted write there is a short lockout. It is sized as three card clocks plus two bus clocks, which is five cycles here. During the lockout, and for as long as an exchange is in progress, further writes are dropped.

Top module: `sdcmd_path`

## Requirements
- R1: After reset every status flag, `resp_index` and all four response words are 0. `cmd_oe`, `wr_busy` and `cmd_active` are 0, and `cmd_out` idles at 1.
- R2: Transmission starts when a write is accepted with control bit 10 (enable) set and bit 9 (deferred start) clear. From the next cycle, `cmd_oe` is high for exactly 48 cycles and `cmd_out` carries the frame in this order:
  - a start bit 0,
  - a transmission bit 1,
  - the index from control bits 5:0,
  - the 32-bit argument,
  - CRC7 (generator x^7+x^3+1) over those first 40 bits,
  - an end bit 1.
- R3: With control bit 6 (reply expected) clear, the block takes in no reply, whatever the value of bit 7. `st_sent` rises in the cycle after the last frame bit, the block goes idle, and the index and word outputs keep their values.
- R4: With bit 6 set and bit 7 clear, the block captures a 48-bit short reply. `resp_index` = reply bits 45:40. `resp_w0` = bits 39:8. The other three words become 0. `st_resp_end` is set when all of these hold:
  - the leading two bits are 00,
  - the CRC7 over bits 47:8 matches bits 7:1,
  - the end bit is 1.
- R5: With bits 6 and 7 both set, the block captures a 136-bit long reply.
  - `resp_index` reads 6'h3F.
  - The words hold reply bits 127:1, with `resp_w0` holding the top 32 bits and bit 0 of `resp_w3` reading 0.
  - The CRC7 covers only bits 127:8.
- R6: A CRC mismatch or an end bit of 0 sets `st_crc_fail` instead of `st_resp_end`. The captured index and words are stored all the same.
- R7: Outside interrupt mode, a reply start bit (0) is accepted on any of the first 64 clock edges after the last command bit. If no start bit arrives in that window, `st_timeout` is set and the block returns to idle.
- R8: With bit 8 (interrupt wait) set, no timeout occurs. While the block is waiting, an `irq_req` pulse returns it to idle without setting any flag.
- R9: With bit 9 set, an enabled write leaves `cmd_oe` low, with `cmd_active` high, until `pend_go` is sampled high. The first frame bit appears in the following cycle.
- R10: Each accepted write raises `wr_busy` for the next five cycles. A write made while `wr_busy` is high is ignored.
- R11: A write made while `cmd_active` is high is ignored. Every accepted write clears all four status flags.
- R12: An accepted write with bit 10 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for control word and argument |
| cfg_ctrl | input | 11 | Control word (index, reply, long, interrupt, deferred, enable) |
| cfg_arg | input | 32 | Command argument |
| pend_go | input | 1 | Release strobe for deferred start |
| irq_req | input | 1 | Interrupt request ending an interrupt-mode wait |
| cmd_in | input | 1 | Sampled command line from the card |
| cmd_out | output | 1 | Command line value driven to the card |
| cmd_oe | output | 1 | Command line output enable |
| wr_busy | output | 1 | Write lockout window in progress |
| cmd_active | output | 1 | An exchange is in progress |
| st_sent | output | 1 | Command sent, no reply expected |
| st_resp_end | output | 1 | Reply received with good CRC |
| st_crc_fail | output | 1 | Reply received with bad CRC or end bit |
| st_timeout | output | 1 | No reply started in the window |
| resp_index | output | 6 | Index field of the last reply |
| resp_w0 | output | 32 | Reply word 0 (most significant) |
| resp_w1 | output | 32 | Reply word 1 |
| resp_w2 | output | 32 | Reply word 2 |
| resp_w3 | output | 32 | Reply word 3 |

## Verification
An error in the transmit bit counter or the frame shifter shows at once on `cmd_out`. It appears as a misplaced or corrupted bit within the 48 frame cycles, or as a frame whose `cmd_oe` window is too short or too long.

A faulty reply counter or CRC evaluation shows one cycle after the last reply bit. The symptom is the wrong flag among end, CRC-fail and timeout, or wrongly placed words.

A timer off by one moves the timeout edge by one cycle against the 64-edge window. A broken lockout or mode latch shows as a transmission starting where none may, or failing to start.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int CMD_BITS   = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int KEEP_BITS  = 128;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PEND,
    S_SEND,
    S_WAIT,
    S_RECV
  } sdcmd_state_e;

  // Field order follows the bit positions of the control word (bit 10 down to 0).
  typedef struct packed {
    logic       en;
    logic       pend;
    logic       intr;
    logic       lng;
    logic       rsp;
    logic [5:0] idx;
  } sdcmd_ctrl_t;

  // One serial step of the CRC7 register, generator x^7 + x^3 + 1.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_40(input logic [39:0] m);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, m[i]);
    return c;
  endfunction

  function automatic logic [6:0] crc7_120(input logic [119:0] m);
    logic [6:0] c;
    c = '0;
    for (int i = 119; i >= 0; i--) c = crc7_step(c, m[i]);
    return c;
  endfunction

  function automatic logic [CMD_BITS-1:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, crc7_40({2'b01, idx, arg}), 1'b1};
  endfunction

endpackage

// File: rtl/sdcmd_lockout.sv
module sdcmd_lockout #(
  parameter int LOCK_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (accept)        cnt <= CW'(LOCK_CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R10: an accepted write always opens the lockout window
  a_r10_lock_opens: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic        shift,
  output logic        bit_out
);
  logic [CMD_BITS-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '1;
    else if (load)  sr <= cmd_frame(idx, arg);
    else if (shift) sr <= {sr[CMD_BITS-2:0], 1'b1};
  end

  assign bit_out = sr[CMD_BITS-1];

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        first,
  input  logic        lng,
  input  logic        bit_in,
  output logic        last,
  output logic        crc_ok,
  output logic [5:0]  resp_index,
  output logic [31:0] w0,
  output logic [31:0] w1,
  output logic [31:0] w2,
  output logic [31:0] w3
);
  localparam int CW = $clog2(LONG_BITS + 1);

  logic [KEEP_BITS-2:0] sr;
  logic [KEEP_BITS-1:0] nxt;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        len_m1;

  assign nxt    = {sr, bit_in};
  assign len_m1 = lng ? CW'(LONG_BITS - 1) : CW'(SHORT_BITS - 1);
  assign last   = capture && !first && (cnt == len_m1);

  always_comb begin
    if (lng) crc_ok = (crc7_120(nxt[127:8]) == nxt[7:1]) && nxt[0];
    else     crc_ok = (crc7_40(nxt[47:8]) == nxt[7:1]) && nxt[0] && (nxt[47:46] == 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '1;
      cnt <= '0;
      resp_index <= '0;
      w0 <= '0;
      w1 <= '0;
      w2 <= '0;
      w3 <= '0;
    end else if (capture) begin
      sr  <= nxt[KEEP_BITS-2:0];
      cnt <= first ? CW'(1) : cnt + 1'b1;
      if (last) begin
        cnt <= '0;
        if (lng) begin
          resp_index <= 6'h3F;
          w0 <= nxt[127:96];
          w1 <= nxt[95:64];
          w2 <= nxt[63:32];
          w3 <= {nxt[31:1], 1'b0};
        end else begin
          resp_index <= nxt[45:40];
          w0 <= nxt[39:8];
          w1 <= '0;
          w2 <= '0;
          w3 <= '0;
        end
      end
    end
  end

  // R5: a long reply always reports the all-ones index
  a_r5_long_index: assert property (@(posedge clk) disable iff (!rst_n)
    (last && lng) |=> (resp_index == 6'h3F));

  // R4: a short reply leaves only the first word populated
  a_r4_short_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !lng) |=> (w1 == '0 && w2 == '0 && w3 == '0));

endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
  import sdcmd_pkg::*;
#(
  parameter int TMO_CYCLES     = 64,
  parameter int LOCK_CARD_CLKS = 3,
  parameter int LOCK_BUS_CLKS  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [10:0] cfg_ctrl,
  input  logic [31:0] cfg_arg,
  input  logic        pend_go,
  input  logic        irq_req,
  input  logic        cmd_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        wr_busy,
  output logic        cmd_active,
  output logic        st_sent,
  output logic        st_resp_end,
  output logic        st_crc_fail,
  output logic        st_timeout,
  output logic [5:0]  resp_index,
  output logic [31:0] resp_w0,
  output logic [31:0] resp_w1,
  output logic [31:0] resp_w2,
  output logic [31:0] resp_w3
);
  localparam int LOCK_CYCLES = LOCK_CARD_CLKS + LOCK_BUS_CLKS;
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam int BW = $clog2(CMD_BITS);

  sdcmd_state_e state;
  sdcmd_ctrl_t  wr_ctrl;
  logic         rsp_q, lng_q, intr_q;
  logic [BW-1:0] bcnt;
  logic [TW-1:0] tmr;

  // Named internal events
  logic accept, launch, send_done, tx_bit;
  logic rx_first, rx_capture, rx_last, rx_crc_ok;
  logic tmo_hit, irq_exit;

  assign wr_ctrl    = cfg_ctrl;
  assign cmd_active = (state != S_IDLE);
  assign accept     = cfg_we && !wr_busy && !cmd_active;
  assign launch     = accept && wr_ctrl.en;
  assign send_done  = (state == S_SEND) && (bcnt == BW'(CMD_BITS - 1));
  assign rx_first   = (state == S_WAIT) && !cmd_in;
  assign rx_capture = rx_first || (state == S_RECV);
  assign tmo_hit    = (state == S_WAIT) && cmd_in && !intr_q && (tmr == TW'(TMO_CYCLES - 1));
  assign irq_exit   = (state == S_WAIT) && cmd_in && intr_q && irq_req;

  sdcmd_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(wr_busy)
  );

  sdcmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .idx(wr_ctrl.idx), .arg(cfg_arg),
    .shift(state == S_SEND), .bit_out(tx_bit)
  );

  sdcmd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .capture(rx_capture), .first(rx_first), .lng(lng_q),
    .bit_in(cmd_in), .last(rx_last), .crc_ok(rx_crc_ok), .resp_index(resp_index),
    .w0(resp_w0), .w1(resp_w1), .w2(resp_w2), .w3(resp_w3)
  );

  assign cmd_oe  = (state == S_SEND);
  assign cmd_out = cmd_oe ? tx_bit : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bcnt   <= '0;
      tmr    <= '0;
      rsp_q  <= 1'b0;
      lng_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      if (accept) begin
        rsp_q  <= wr_ctrl.rsp;
        lng_q  <= wr_ctrl.lng;
        intr_q <= wr_ctrl.intr;
      end
      case (state)
        S_IDLE: if (launch) begin
          state <= wr_ctrl.pend ? S_PEND : S_SEND;
          bcnt  <= '0;
        end
        S_PEND: if (pend_go) state <= S_SEND;
        S_SEND: begin
          bcnt <= bcnt + 1'b1;
          if (send_done) begin
            bcnt  <= '0;
            tmr   <= '0;
            state <= rsp_q ? S_WAIT : S_IDLE;
          end
        end
        S_WAIT: begin
          if (rx_first)                 state <= S_RECV;
          else if (tmo_hit || irq_exit) state <= S_IDLE;
          else if (!intr_q)             tmr <= tmr + 1'b1;
        end
        S_RECV: if (rx_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sent     <= 1'b0;
      st_resp_end <= 1'b0;
      st_crc_fail <= 1'b0;
      st_timeout  <= 1'b0;
    end else if (accept) begin
      st_sent     <= 1'b0;
      st_resp_end <= 1'b0;
      st_crc_fail <= 1'b0;
      st_timeout  <= 1'b0;
    end else begin
      if (send_done && !rsp_q)  st_sent     <= 1'b1;
      if (tmo_hit)              st_timeout  <= 1'b1;
      if (rx_last && rx_crc_ok) st_resp_end <= 1'b1;
      if (rx_last && !rx_crc_ok) st_crc_fail <= 1'b1;
    end
  end

  // R2: the drive window closes only after the final frame bit
  a_r2_frame_span: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> ($past(bcnt) == BW'(CMD_BITS - 1)));

  // R3: no reply expected means idle right after the frame
  a_r3_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (send_done && !rsp_q) |=> !cmd_active);

  // R6: at most one completion flag at a time
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_sent, st_resp_end, st_crc_fail, st_timeout}));

  // R7 / R8: a timeout only comes from a timed wait
  a_r7_timeout_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_timeout) |-> ($past(state) == S_WAIT && !$past(intr_q)));

  // R9: held command stays off the line until released
  a_r9_pend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PEND && !pend_go) |=> !cmd_oe);

  // R10: a write during lockout cannot start an exchange
  a_r10_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_busy && !cmd_active) |=> !cmd_active);

  // R11: a write during an exchange leaves the mode latches untouched
  a_r11_active_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cmd_active) |=> ($stable(rsp_q) && $stable(lng_q) && $stable(intr_q)));

endmodule

// File: tb/tb_sdcmd_path.sv
module tb_sdcmd_path;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_ctrl = '0;
  logic [31:0] cfg_arg = '0;
  logic        pend_go = 1'b0;
  logic        irq_req = 1'b0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, wr_busy, cmd_active;
  logic        st_sent, st_resp_end, st_crc_fail, st_timeout;
  logic [5:0]  resp_index;
  logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;

  always #10 clk = ~clk;

  sdcmd_path dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl), .cfg_arg(cfg_arg),
    .pend_go(pend_go), .irq_req(irq_req), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .wr_busy(wr_busy), .cmd_active(cmd_active), .st_sent(st_sent), .st_resp_end(st_resp_end),
    .st_crc_fail(st_crc_fail), .st_timeout(st_timeout), .resp_index(resp_index),
    .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [5:0]   e_idx = '0;
  logic [127:0] e_words = '0;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [1:0]  mode;   // 0 none, 1 short, 2 long
    logic        lbit;
    logic        bad;
    logic [7:0]  dly;
    logic [31:0] seed;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{6'd8,  32'h000001AA, 2'd1, 1'b0, 1'b0, 8'd0,  32'h00000120},
    '{6'd0,  32'h00000000, 2'd0, 1'b0, 1'b0, 8'd0,  32'h0},
    '{6'd55, 32'h12345678, 2'd0, 1'b1, 1'b0, 8'd0,  32'h0},
    '{6'd17, 32'h00000000, 2'd1, 1'b0, 1'b0, 8'd63, 32'h00000900},
    '{6'd2,  32'h00000000, 2'd2, 1'b0, 1'b0, 8'd5,  32'hC0FFEE11},
    '{6'd9,  32'hABCD0000, 2'd1, 1'b0, 1'b1, 8'd2,  32'h00000700},
    '{6'd10, 32'h0000FFFF, 2'd2, 1'b0, 1'b1, 8'd1,  32'h13579BDF},
    '{6'd63, 32'hFFFFFFFF, 2'd1, 1'b0, 1'b0, 8'd10, 32'h80000000}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Polynomial long division of msg * x^7 by x^7 + x^3 + 1.
  function automatic logic [6:0] div_crc(input logic [119:0] msg, input int n);
    logic [7:0] r;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      r = {r[6:0], msg[i]};
      if (r[7]) r = r ^ 8'h89;
    end
    for (int i = 0; i < 7; i++) begin
      r = {r[6:0], 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, div_crc({80'b0, 2'b01, idx, arg}, 40), 1'b1};
  endfunction

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr(input logic [10:0] ctl, input logic [31:0] arg);
    cfg_we = 1'b1; cfg_ctrl = ctl; cfg_arg = arg;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Samples 48 frame bits starting now; returns at the falling edge after the frame.
  task automatic grab(output logic [47:0] f, output bit oe_ok);
    f[47] = cmd_out; oe_ok = cmd_oe;
    for (int i = 1; i < 48; i++) begin
      @(negedge clk);
      f[47-i] = cmd_out;
      oe_ok = oe_ok && cmd_oe;
    end
    @(negedge clk);
  endtask

  task automatic drive_resp(input logic [135:0] rf, input int len, input int dly);
    for (int d = 0; d < dly; d++) begin
      cmd_in = 1'b1;
      @(negedge clk);
    end
    for (int j = len - 1; j >= 0; j--) begin
      cmd_in = rf[j];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic run_row(input vec_t v);
    logic [47:0]  f;
    bit           oe;
    logic [135:0] rf;
    logic [119:0] body;
    logic [6:0]   c;
    logic [10:0]  ctl;
    int           len;
    ctl = {1'b1, 1'b0, 1'b0, (v.mode == 2'd2) || v.lbit, v.mode != 2'd0, v.idx};
    wr(ctl, v.arg);
    grab(f, oe);
    chk(oe, "R2 oe window", 128'(oe), 128'(1));
    chk(f == exp_frame(v.idx, v.arg), "R2 frame bits", 128'(f), 128'(exp_frame(v.idx, v.arg)));
    if (v.idx == 6'd0 && v.arg == 32'h0) chk(f[7:1] == 7'h4A, "R2 crc idx0", 128'(f[7:1]), 128'(7'h4A));
    if (v.idx == 6'd8 && v.arg == 32'h1AA) chk(f[7:1] == 7'h43, "R2 crc idx8", 128'(f[7:1]), 128'(7'h43));
    chk(!cmd_oe, "R2 oe off after frame", 128'(cmd_oe), 128'(0));
    if (v.mode == 2'd0) begin
      chk(st_sent && !cmd_active, "R3 sent and idle", 128'({st_sent, cmd_active}), 128'(2'b10));
      chk({resp_w0, resp_w1, resp_w2, resp_w3} == e_words && resp_index == e_idx, "R3 regs kept",
          {resp_w0, resp_w1, resp_w2, resp_w3}, e_words);
    end else begin
      chk(cmd_active && !st_sent, "R4 waiting for reply", 128'({cmd_active, st_sent}), 128'(2'b10));
      if (v.mode == 2'd1) begin
        c = div_crc({80'b0, 2'b00, v.idx, v.seed}, 40) ^ {6'b0, v.bad};
        rf = {88'b0, 2'b00, v.idx, v.seed, c, 1'b1};
        len = 48;
        e_idx = v.idx;
        e_words = {v.seed, 96'b0};
      end else begin
        body = {v.seed, ~v.seed, v.seed ^ 32'h5A5A5A5A, v.seed[23:0]};
        c = div_crc(body, 120) ^ {6'b0, v.bad};
        rf = {2'b00, 6'h3F, body, c, 1'b1};
        len = 136;
        e_idx = 6'h3F;
        e_words = {body, c, 1'b0};
      end
      drive_resp(rf, len, int'(v.dly));
      if (v.bad)
        chk(st_crc_fail && !st_resp_end, "R6 crc fail flag", 128'({st_crc_fail, st_resp_end}), 128'(2'b10));
      else
        chk(st_resp_end && !st_crc_fail, v.mode == 2'd1 ? "R4 short end flag" : "R5 long end flag",
            128'({st_resp_end, st_crc_fail}), 128'(2'b10));
      chk(resp_index == e_idx, v.mode == 2'd1 ? "R4 index" : "R5 index", 128'(resp_index), 128'(e_idx));
      chk({resp_w0, resp_w1, resp_w2, resp_w3} == e_words, v.bad ? "R6 words stored" : "R4 R5 words",
          {resp_w0, resp_w1, resp_w2, resp_w3}, e_words);
      chk(!cmd_active, "R4 idle after reply", 128'(cmd_active), 128'(0));
    end
  endtask

  initial begin
    logic [47:0] f;
    bit          oe;
    bit          quiet;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!st_sent && !st_resp_end && !st_crc_fail && !st_timeout, "R1 flags",
        128'({st_sent, st_resp_end, st_crc_fail, st_timeout}), 128'(0));
    chk(resp_index == '0 && {resp_w0, resp_w1, resp_w2, resp_w3} == '0, "R1 reply regs",
        {resp_w0, resp_w1, resp_w2, resp_w3}, 128'(0));
    chk(!cmd_oe && cmd_out && !wr_busy && !cmd_active, "R1 line and busy",
        128'({cmd_oe, cmd_out, wr_busy, cmd_active}), 128'(4'b0100));
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) run_row(VEC[i]);

    // R7 timeout window
    wr({1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd5}, 32'h00000042);
    grab(f, oe);
    repeat (63) @(negedge clk);
    chk(!st_timeout && cmd_active, "R7 still waiting at edge 63", 128'({st_timeout, cmd_active}), 128'(2'b01));
    @(negedge clk);
    chk(st_timeout && !cmd_active, "R7 timeout at edge 64", 128'({st_timeout, cmd_active}), 128'(2'b10));

    // R11 flag clear, R12 enable clear, R10 lockout
    wr({1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd7}, 32'h0);
    chk(!st_timeout && !cmd_active && !cmd_oe, "R11 R12 flags cleared, no start",
        128'({st_timeout, cmd_active, cmd_oe}), 128'(0));
    chk(wr_busy, "R10 busy after write", 128'(wr_busy), 128'(1));
    @(negedge clk);
    wr({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1}, 32'h0);
    chk(!cmd_active && !cmd_oe, "R10 locked write ignored", 128'({cmd_active, cmd_oe}), 128'(0));
    repeat (2) @(negedge clk);
    chk(wr_busy, "R10 busy in fifth cycle", 128'(wr_busy), 128'(1));
    @(negedge clk);
    chk(!wr_busy, "R10 busy ends after five cycles", 128'(wr_busy), 128'(0));
    wr({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1}, 32'h0BADF00D);
    grab(f, oe);
    chk(oe && f == exp_frame(6'd1, 32'h0BADF00D), "R10 write after lockout sent", 128'(f),
        128'(exp_frame(6'd1, 32'h0BADF00D)));
    chk(st_sent, "R3 sent after lockout write", 128'(st_sent), 128'(1));

    // R9 deferred start, R11 write during exchange
    wr({1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd12}, 32'hCAFE0001);
    quiet = !cmd_oe && cmd_active;
    repeat (8) begin
      @(negedge clk);
      quiet = quiet && !cmd_oe && cmd_active;
    end
    chk(quiet, "R9 held until release", 128'(quiet), 128'(1));
    wr({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd20}, 32'h0);
    chk(!cmd_oe && cmd_active, "R11 write while active ignored", 128'({cmd_oe, cmd_active}), 128'(2'b01));
    pend_go = 1'b1;
    @(negedge clk);
    pend_go = 1'b0;
    grab(f, oe);
    chk(oe && f == exp_frame(6'd12, 32'hCAFE0001), "R9 R11 original frame after release", 128'(f),
        128'(exp_frame(6'd12, 32'hCAFE0001)));

    // R8 interrupt wait
    wr({1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd3}, 32'h0);
    grab(f, oe);
    repeat (100) @(negedge clk);
    chk(cmd_active && !st_timeout, "R8 no timeout in interrupt mode", 128'({cmd_active, st_timeout}), 128'(2'b10));
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk(!cmd_active && !st_sent && !st_resp_end && !st_crc_fail && !st_timeout, "R8 irq ends wait quietly",
        128'({cmd_active, st_sent, st_resp_end, st_crc_fail, st_timeout}), 128'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule